// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block keeps the interrupt status word of a packet DMA engine. Single-cycle event pulses from the transmit and receive processes set sticky status bits. Software reads the word through a small register port and clears bits by writing ones. A second register holds one enable per status bit. From the enabled bits the block builds two sticky summary flags: a normal one for routine completion events and an abnormal one for error and stall events. A single interrupt line is driven from the summaries, each gated by its own enable.

A few sources are qualified or have side effects. A receive frame longer than the watchdog limit raises the watchdog bit. A host-owned receive descriptor raises the buffer-unavailable bit only when the descriptor before it was owned by the DMA. The receive-done event wipes a pending early-receive flag. A fatal bus error raises a halt output towards the engine that faulted. That output stays up until the error bit is cleared or the block is reset.

Top module: `dma_irq_status`

## Requirements
- R1: Each event input sets its own status bit on the clock edge where it is high: tx done bit 0, tx stopped 1, tx buffer unavailable 2, jabber 3, rx overflow 4, tx underflow 5, rx done 6, rx buffer unavailable 7, rx stopped 8, rx watchdog 9, early tx 10, fatal bus error 13, early rx 14. The bit stays set until cleared. The status word reads at address 0 and the enable word reads at address 1. Any other address reads 0.
- R2: A write to address 0 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. If a set event and a clear of the same bit fall on the same edge, the bit stays set.
- R3: The normal summary (bit 16) is set on the edge after any of bits 0, 2, 6 or 14 is 1 while its enable is 1. It stays set until a write-1 clear. If an enabled source is still 1 on the clearing edge, the summary sets again.
- R4: The abnormal summary (bit 15) follows the same rule as R3, with bits 1, 3, 4, 5, 7, 8, 9, 10 and 13 as its sources.
- R5: A status bit whose enable is 0 is still recorded, but it never sets either summary.
- R6: `irq` is high exactly when (bit 16 and enable 16) or (bit 15 and enable 15).
- R7: An rx done event clears the early-receive bit 14 on the same edge that sets bit 6.
- R8: An rx frame end with a length greater than MAX_FRAME (2048) sets bit 9. A length equal to MAX_FRAME, or a length with no frame end, does not.
- R9: A host-owned rx descriptor event sets bit 7 only if `rxPrevDmaOwned` is 1 on the same edge.
- R10: A tx or rx fatal bus error sets bit 13 and raises `txHalt` or `rxHalt` respectively. The halt stays high until bit 13 is cleared by a write or the block is reset. Clearing other bits has no effect on it.
- R11: Bits 12:11 and 31:17 of both registers read 0, and writes do not set them.
- R12: After reset, the status word, the enable word, `irq`, `txHalt` and `rxHalt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address (0 status, 1 enable) |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Combinational read data |
| evTxDone | input | 1 | Transmit frame completed |
| evTxStopped | input | 1 | Transmit process entered stopped |
| evTxBufUnavail | input | 1 | Transmit descriptor not available |
| evJabber | input | 1 | Transmit jabber timeout |
| evRxOverflow | input | 1 | Receive FIFO overflow |
| evTxUnderflow | input | 1 | Transmit FIFO underflow |
| evRxDone | input | 1 | Receive frame completed |
| evRxDescHost | input | 1 | Next rx descriptor is host-owned |
| rxPrevDmaOwned | input | 1 | Previous rx descriptor was DMA-owned |
| evRxStopped | input | 1 | Receive process entered stopped |
| evRxFrameEnd | input | 1 | Received frame ended, length valid |
| rxFrameLen | input | LEN_W | Received frame length in bytes |
| evEarlyTx | input | 1 | Frame fully moved into transmit FIFO |
| evEarlyRx | input | 1 | First rx buffer of a frame filled |
| evBusErrTx | input | 1 | Fatal bus error on the transmit engine |
| evBusErrRx | input | 1 | Fatal bus error on the receive engine |
| irq | output | 1 | Interrupt request |
| txHalt | output | 1 | Stop all transmit engine bus accesses |
| rxHalt | output | 1 | Stop all receive engine bus accesses |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 2-bit address, a 16-bit length field and a watchdog limit of 2048. The 16-bit length lets the bench place frames at exactly 2048 and at 2049, so the strict comparison of R8 is tested right at its edge. The 2-bit address reaches an unmapped address, which must read 0. A full 32-bit write of ones reaches the upper bits that must ignore writes.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int STAT_W = 17;

  // status bit positions
  localparam int B_TX_DONE      = 0;
  localparam int B_TX_STOP      = 1;
  localparam int B_TX_NOBUF     = 2;
  localparam int B_JABBER       = 3;
  localparam int B_RX_OVF       = 4;
  localparam int B_TX_UNF       = 5;
  localparam int B_RX_DONE      = 6;
  localparam int B_RX_NOBUF     = 7;
  localparam int B_RX_STOP      = 8;
  localparam int B_RX_WDOG      = 9;
  localparam int B_EARLY_TX     = 10;
  localparam int B_BUS_ERR      = 13;
  localparam int B_EARLY_RX     = 14;
  localparam int B_ABN_SUM      = 15;
  localparam int B_NRM_SUM      = 16;

  localparam logic [STAT_W-1:0] NORMAL_SRC   = STAT_W'((1 << B_TX_DONE) | (1 << B_TX_NOBUF)
                                                     | (1 << B_RX_DONE) | (1 << B_EARLY_RX));
  localparam logic [STAT_W-1:0] ABNORMAL_SRC = STAT_W'((1 << B_TX_STOP) | (1 << B_JABBER)
                                                     | (1 << B_RX_OVF)  | (1 << B_TX_UNF)
                                                     | (1 << B_RX_NOBUF) | (1 << B_RX_STOP)
                                                     | (1 << B_RX_WDOG) | (1 << B_EARLY_TX)
                                                     | (1 << B_BUS_ERR));
  localparam logic [STAT_W-1:0] SUMMARY_BITS = STAT_W'((1 << B_ABN_SUM) | (1 << B_NRM_SUM));
  localparam logic [STAT_W-1:0] IMPL_BITS    = NORMAL_SRC | ABNORMAL_SRC | SUMMARY_BITS;

  // strobes from control to datapath
  typedef struct packed {
    logic [STAT_W-1:0] setEv;
    logic [STAT_W-1:0] clrMask;
    logic              enWr;
    logic [STAT_W-1:0] enData;
    logic              txHaltSet;
    logic              rxHaltSet;
    logic              wipeEarlyRx;
  } strobe_t;

endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 16,
  parameter int MAX_FRAME   = 2048,
  parameter int STATUS_ADDR = 0,
  parameter int ENABLE_ADDR = 1
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evTxDone,
  input  logic              evTxStopped,
  input  logic              evTxBufUnavail,
  input  logic              evJabber,
  input  logic              evRxOverflow,
  input  logic              evTxUnderflow,
  input  logic              evRxDone,
  input  logic              evRxDescHost,
  input  logic              rxPrevDmaOwned,
  input  logic              evRxStopped,
  input  logic              evRxFrameEnd,
  input  logic [LEN_W-1:0]  rxFrameLen,
  input  logic              evEarlyTx,
  input  logic              evEarlyRx,
  input  logic              evBusErrTx,
  input  logic              evBusErrRx,
  output strobe_t           stb
);

  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_FRAME);

  logic statSel;
  logic enSel;
  logic frameTooLong;
  logic noBufQualified;
  logic [DATA_W-STAT_W-1:0] unusedWrHigh;

  assign statSel        = wrEn && (wrAddr == ADDR_W'(STATUS_ADDR));
  assign enSel          = wrEn && (wrAddr == ADDR_W'(ENABLE_ADDR));
  assign frameTooLong   = evRxFrameEnd && (rxFrameLen > LEN_LIMIT);
  assign noBufQualified = evRxDescHost && rxPrevDmaOwned;
  assign unusedWrHigh   = wrData[DATA_W-1:STAT_W];

  always_comb begin
    stb = '0;
    stb.setEv[B_TX_DONE]  = evTxDone;
    stb.setEv[B_TX_STOP]  = evTxStopped;
    stb.setEv[B_TX_NOBUF] = evTxBufUnavail;
    stb.setEv[B_JABBER]   = evJabber;
    stb.setEv[B_RX_OVF]   = evRxOverflow;
    stb.setEv[B_TX_UNF]   = evTxUnderflow;
    stb.setEv[B_RX_DONE]  = evRxDone;
    stb.setEv[B_RX_NOBUF] = noBufQualified;
    stb.setEv[B_RX_STOP]  = evRxStopped;
    stb.setEv[B_RX_WDOG]  = frameTooLong;
    stb.setEv[B_EARLY_TX] = evEarlyTx;
    stb.setEv[B_BUS_ERR]  = evBusErrTx | evBusErrRx;
    stb.setEv[B_EARLY_RX] = evEarlyRx;
    stb.clrMask           = statSel ? (wrData[STAT_W-1:0] & IMPL_BITS) : '0;
    stb.enWr              = enSel;
    stb.enData            = wrData[STAT_W-1:0] & IMPL_BITS;
    stb.txHaltSet         = evBusErrTx;
    stb.rxHaltSet         = evBusErrRx;
    stb.wipeEarlyRx       = evRxDone;
  end

endmodule

// File: rtl/dma_irq_dpath.sv
module dma_irq_dpath
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int STATUS_ADDR = 0,
  parameter int ENABLE_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [STAT_W-1:0] statusQ,
  output logic [STAT_W-1:0] enableQ,
  output logic              txHaltQ,
  output logic              rxHaltQ
);

  logic [STAT_W-1:0] statNext;
  logic [STAT_W-1:0] liveSrc;

  assign liveSrc = statusQ & enableQ;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (!IMPL_BITS[i]) begin : g_rsvd
      assign statNext[i] = 1'b0;
    end else if (SUMMARY_BITS[i]) begin : g_sum
      localparam logic [STAT_W-1:0] SRC = (i == B_NRM_SUM) ? NORMAL_SRC : ABNORMAL_SRC;
      assign statNext[i] = (|(liveSrc & SRC)) | (statusQ[i] & ~stb.clrMask[i]);
    end else if (i == B_EARLY_RX) begin : g_early
      assign statNext[i] = ~stb.wipeEarlyRx
                         & (stb.setEv[i] | (statusQ[i] & ~stb.clrMask[i]));
    end else begin : g_plain
      assign statNext[i] = stb.setEv[i] | (statusQ[i] & ~stb.clrMask[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      txHaltQ <= 1'b0;
      rxHaltQ <= 1'b0;
    end else begin
      statusQ <= statNext;
      if (stb.enWr) enableQ <= stb.enData;
      if (stb.txHaltSet)                 txHaltQ <= 1'b1;
      else if (stb.clrMask[B_BUS_ERR])   txHaltQ <= 1'b0;
      if (stb.rxHaltSet)                 rxHaltQ <= 1'b1;
      else if (stb.clrMask[B_BUS_ERR])   rxHaltQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(STATUS_ADDR))      rdData[STAT_W-1:0] = statusQ;
    else if (rdAddr == ADDR_W'(ENABLE_ADDR)) rdData[STAT_W-1:0] = enableQ;
  end

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 16,
  parameter int MAX_FRAME   = 2048,
  parameter int STATUS_ADDR = 0,
  parameter int ENABLE_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              evTxDone,
  input  logic              evTxStopped,
  input  logic              evTxBufUnavail,
  input  logic              evJabber,
  input  logic              evRxOverflow,
  input  logic              evTxUnderflow,
  input  logic              evRxDone,
  input  logic              evRxDescHost,
  input  logic              rxPrevDmaOwned,
  input  logic              evRxStopped,
  input  logic              evRxFrameEnd,
  input  logic [LEN_W-1:0]  rxFrameLen,
  input  logic              evEarlyTx,
  input  logic              evEarlyRx,
  input  logic              evBusErrTx,
  input  logic              evBusErrRx,
  output logic              irq,
  output logic              txHalt,
  output logic              rxHalt
);

  strobe_t           stb;
  logic [STAT_W-1:0] statusQ;
  logic [STAT_W-1:0] enableQ;

  dma_irq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME),
    .STATUS_ADDR(STATUS_ADDR), .ENABLE_ADDR(ENABLE_ADDR)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evTxDone(evTxDone), .evTxStopped(evTxStopped), .evTxBufUnavail(evTxBufUnavail),
    .evJabber(evJabber), .evRxOverflow(evRxOverflow), .evTxUnderflow(evTxUnderflow),
    .evRxDone(evRxDone), .evRxDescHost(evRxDescHost), .rxPrevDmaOwned(rxPrevDmaOwned),
    .evRxStopped(evRxStopped), .evRxFrameEnd(evRxFrameEnd), .rxFrameLen(rxFrameLen),
    .evEarlyTx(evEarlyTx), .evEarlyRx(evEarlyRx),
    .evBusErrTx(evBusErrTx), .evBusErrRx(evBusErrRx),
    .stb(stb)
  );

  dma_irq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STATUS_ADDR(STATUS_ADDR), .ENABLE_ADDR(ENABLE_ADDR)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rdAddr(rdAddr), .rdData(rdData),
    .statusQ(statusQ), .enableQ(enableQ),
    .txHaltQ(txHalt), .rxHaltQ(rxHalt)
  );

  assign irq = (statusQ[B_NRM_SUM] & enableQ[B_NRM_SUM])
             | (statusQ[B_ABN_SUM] & enableQ[B_ABN_SUM]);

endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 16,
  parameter int MAX_FRAME   = 2048,
  parameter int STATUS_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [STAT_W-1:0] wrLow,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              evTxDone,
  input logic              evRxDone,
  input logic              evRxDescHost,
  input logic              rxPrevDmaOwned,
  input logic              evRxFrameEnd,
  input logic [LEN_W-1:0]  rxFrameLen,
  input logic              evBusErrTx,
  input logic              evBusErrRx,
  input logic [STAT_W-1:0] statusQ,
  input logic [STAT_W-1:0] enableQ,
  input logic              irq,
  input logic              txHalt,
  input logic              rxHalt
);

  logic statWr;
  assign statWr = wrEn && (wrAddr == ADDR_W'(STATUS_ADDR));

  assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
    evTxDone |=> statusQ[B_TX_DONE]);

  assert_sticky_w1c_R2: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[B_TX_DONE] && !(statWr && wrLow[B_TX_DONE])) |=> statusQ[B_TX_DONE]);

  assert_normal_sum_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & enableQ & NORMAL_SRC)) |=> statusQ[B_NRM_SUM]);

  assert_abnormal_sum_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & enableQ & ABNORMAL_SRC)) |=> statusQ[B_ABN_SUM]);

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!enableQ[B_NRM_SUM] && !enableQ[B_ABN_SUM]) |-> !irq);

  assert_early_rx_wipe_R7: assert property (@(posedge clk) disable iff (!rstN)
    evRxDone |=> (!statusQ[B_EARLY_RX] && statusQ[B_RX_DONE]));

  assert_wdog_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!statusQ[B_RX_WDOG] && !(statWr && 1'b0)
     && !(evRxFrameEnd && (rxFrameLen > LEN_W'(MAX_FRAME)))) |=> !statusQ[B_RX_WDOG]);

  assert_nobuf_qual_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!statusQ[B_RX_NOBUF] && !(evRxDescHost && rxPrevDmaOwned)) |=> !statusQ[B_RX_NOBUF]);

  assert_halt_raise_R10: assert property (@(posedge clk) disable iff (!rstN)
    (evBusErrTx || evBusErrRx) |=> (statusQ[B_BUS_ERR] && (txHalt || rxHalt)));

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((txHalt || rxHalt) && !(statWr && wrLow[B_BUS_ERR])) |=> (statusQ[B_BUS_ERR]));

  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> (rdData[12:11] == 2'b00 && rdData[DATA_W-1:STAT_W] == '0));

  logic unusedRd;
  assign unusedRd = ^rdAddr;

endmodule

bind dma_irq_status dma_irq_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
  .MAX_FRAME(MAX_FRAME), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrLow(wrData[dma_irq_pkg::STAT_W-1:0]),
  .rdAddr(rdAddr), .rdData(rdData),
  .evTxDone(evTxDone), .evRxDone(evRxDone),
  .evRxDescHost(evRxDescHost), .rxPrevDmaOwned(rxPrevDmaOwned),
  .evRxFrameEnd(evRxFrameEnd), .rxFrameLen(rxFrameLen),
  .evBusErrTx(evBusErrTx), .evBusErrRx(evBusErrRx),
  .statusQ(statusQ), .enableQ(enableQ),
  .irq(irq), .txHalt(txHalt), .rxHalt(rxHalt)
);

// File: tb/dma_irq_status_tb.sv
`timescale 1ns/1ps
module dma_irq_status_tb;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 16;
  localparam logic [31:0] ALL_EN = 32'h0001_E7FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic evTxDone = 0, evTxStopped = 0, evTxBufUnavail = 0, evJabber = 0;
  logic evRxOverflow = 0, evTxUnderflow = 0, evRxDone = 0, evRxDescHost = 0;
  logic rxPrevDmaOwned = 0, evRxStopped = 0, evRxFrameEnd = 0;
  logic [LEN_W-1:0] rxFrameLen = '0;
  logic evEarlyTx = 0, evEarlyRx = 0, evBusErrTx = 0, evBusErrRx = 0;
  logic irq, txHalt, rxHalt;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dma_irq_status u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .evTxDone(evTxDone), .evTxStopped(evTxStopped), .evTxBufUnavail(evTxBufUnavail),
    .evJabber(evJabber), .evRxOverflow(evRxOverflow), .evTxUnderflow(evTxUnderflow),
    .evRxDone(evRxDone), .evRxDescHost(evRxDescHost), .rxPrevDmaOwned(rxPrevDmaOwned),
    .evRxStopped(evRxStopped), .evRxFrameEnd(evRxFrameEnd), .rxFrameLen(rxFrameLen),
    .evEarlyTx(evEarlyTx), .evEarlyRx(evEarlyRx),
    .evBusErrTx(evBusErrTx), .evBusErrRx(evBusErrRx),
    .irq(irq), .txHalt(txHalt), .rxHalt(rxHalt)
  );

  // {event index, expected status bit, normal summary, abnormal summary}
  localparam logic [10:0] VEC [14] = '{
    {4'd0,  5'd0,  1'b1, 1'b0}, {4'd1,  5'd1,  1'b0, 1'b1},
    {4'd2,  5'd2,  1'b1, 1'b0}, {4'd3,  5'd3,  1'b0, 1'b1},
    {4'd4,  5'd4,  1'b0, 1'b1}, {4'd5,  5'd5,  1'b0, 1'b1},
    {4'd6,  5'd6,  1'b1, 1'b0}, {4'd7,  5'd8,  1'b0, 1'b1},
    {4'd8,  5'd10, 1'b0, 1'b1}, {4'd9,  5'd14, 1'b1, 1'b0},
    {4'd10, 5'd13, 1'b0, 1'b1}, {4'd11, 5'd13, 1'b0, 1'b1},
    {4'd12, 5'd7,  1'b0, 1'b1}, {4'd13, 5'd9,  1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setEvent(input int idx, input logic v);
    case (idx)
      0:  evTxDone = v;
      1:  evTxStopped = v;
      2:  evTxBufUnavail = v;
      3:  evJabber = v;
      4:  evRxOverflow = v;
      5:  evTxUnderflow = v;
      6:  evRxDone = v;
      7:  evRxStopped = v;
      8:  evEarlyTx = v;
      9:  evEarlyRx = v;
      10: evBusErrTx = v;
      11: evBusErrRx = v;
      12: begin evRxDescHost = v; rxPrevDmaOwned = v; end
      13: begin evRxFrameEnd = v; rxFrameLen = v ? 16'd3000 : 16'd0; end
      default: ;
    endcase
  endtask

  task automatic pulse(input int idx);
    setEvent(idx, 1'b1);
    @(negedge clk);
    setEvent(idx, 1'b0);
  endtask

  task automatic regWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic clearAll();
    regWrite(2'd0, 32'hFFFF_FFFF);
    regWrite(2'd0, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R12 reset state
    regRead(2'd0, d); check("R12 status", d, 32'h0);
    regRead(2'd1, d); check("R12 enable", d, 32'h0);
    check("R12 irq/halts", {29'd0, irq, txHalt, rxHalt}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R1, R3, R4 over every source
    regWrite(2'd1, ALL_EN);
    for (int k = 0; k < 14; k++) begin
      logic [31:0] bitv;
      logic [31:0] sumv;
      bitv = 32'h1 << VEC[k][6:2];
      sumv = ({31'd0, VEC[k][1]} << 16) | ({31'd0, VEC[k][0]} << 15);
      pulse(int'(VEC[k][10:7]));
      regRead(2'd0, d); check("R1 bit set, summary lags", d, bitv);
      @(negedge clk);
      regRead(2'd0, d); check("R3/R4 summary", d, bitv | sumv);
      check("R6 irq", {31'd0, irq}, 32'h1);
      if (VEC[k][10:7] == 4'd10) check("R10 txHalt", {30'd0, txHalt, rxHalt}, 32'h2);
      if (VEC[k][10:7] == 4'd11) check("R10 rxHalt", {30'd0, txHalt, rxHalt}, 32'h1);
      regWrite(2'd0, 32'hFFFF_FFFF);
      regRead(2'd0, d); check("R3/R4 summary re-sets while source live", d, sumv);
      regWrite(2'd0, 32'hFFFF_FFFF);
      regRead(2'd0, d); check("R3/R4 cleared", d, 32'h0);
      check("R10 halts released", {30'd0, txHalt, rxHalt}, 32'h0);
    end

    // R2: write 0 no effect, set beats clear
    regWrite(2'd1, 32'h0);
    pulse(0);
    regWrite(2'd0, 32'h0);
    regRead(2'd0, d); check("R2 write zero keeps bit", d, 32'h1);
    evTxDone = 1'b1; wrEn = 1'b1; wrAddr = 2'd0; wrData = 32'h1;
    @(negedge clk);
    evTxDone = 1'b0; wrEn = 1'b0; wrData = '0;
    regRead(2'd0, d); check("R2 set wins over clear", d, 32'h1);
    regWrite(2'd0, 32'h1);
    regRead(2'd0, d); check("R2 clear", d, 32'h0);

    // R5: masked source does not reach summary
    regWrite(2'd1, ALL_EN & ~32'h8);
    pulse(3);
    @(negedge clk);
    regRead(2'd0, d); check("R5 masked source", d, 32'h8);
    check("R5 irq low", {31'd0, irq}, 32'h0);
    clearAll();

    // R6: summary enable gating
    regWrite(2'd1, 32'h1);
    pulse(0);
    @(negedge clk);
    regRead(2'd0, d); check("R6 summary without enable", d, 32'h1_0001);
    check("R6 irq gated off", {31'd0, irq}, 32'h0);
    regWrite(2'd1, 32'h1_0001);
    check("R6 irq on", {31'd0, irq}, 32'h1);
    regWrite(2'd1, 32'h0_8001);
    check("R6 abnormal enable only", {31'd0, irq}, 32'h0);
    clearAll();
    regWrite(2'd1, 32'h0);

    // R7: rx done wipes early rx
    pulse(9);
    regRead(2'd0, d); check("R7 early rx set", d, 32'h4000);
    pulse(6);
    regRead(2'd0, d); check("R7 early rx wiped", d, 32'h40);
    clearAll();

    // R8: watchdog boundary
    evRxFrameEnd = 1'b1; rxFrameLen = 16'd2048;
    @(negedge clk);
    evRxFrameEnd = 1'b0; rxFrameLen = 16'd4000;
    @(negedge clk);
    regRead(2'd0, d); check("R8 at limit / no frame end", d, 32'h0);
    evRxFrameEnd = 1'b1; rxFrameLen = 16'd2049;
    @(negedge clk);
    evRxFrameEnd = 1'b0; rxFrameLen = 16'd0;
    regRead(2'd0, d); check("R8 above limit", d, 32'h200);
    clearAll();

    // R9: ownership qualifier
    evRxDescHost = 1'b1; rxPrevDmaOwned = 1'b0;
    @(negedge clk);
    evRxDescHost = 1'b0;
    regRead(2'd0, d); check("R9 prev host-owned", d, 32'h0);
    pulse(12);
    regRead(2'd0, d); check("R9 prev dma-owned", d, 32'h80);
    clearAll();

    // R10: halt held across unrelated clears
    pulse(11);
    regWrite(2'd0, 32'h0000_0001);
    check("R10 halt held", {30'd0, txHalt, rxHalt}, 32'h1);
    regWrite(2'd0, 32'h0000_2000);
    check("R10 halt released by bit 13 clear", {30'd0, txHalt, rxHalt}, 32'h0);
    clearAll();

    // R11: reserved and upper bits
    regWrite(2'd1, 32'hFFFF_FFFF);
    regRead(2'd1, d); check("R11 enable implemented bits", d, ALL_EN);
    regRead(2'd2, d); check("R11 unmapped address", d, 32'h0);
    regWrite(2'd0, 32'hFFFF_FFFF);
    regRead(2'd0, d); check("R11 status write sets nothing", d, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule